// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block sits on the controller side of a single-data-rate synchronous DRAM and turns a stream of user commands into pin activity on the memory's command, bank, address, data and data-mask lines. The user side is one command channel (activate, write, read, precharge of one bank, precharge of every bank) and one write-data channel, both with valid/ready handshakes. A write is accepted only together with its first data word, and that word leaves on the data bus in the same clock as the write command itself. The following words of the burst are pulled from the data channel one per clock.

The burst length (1, 2, 4 or 8) or an endless full-page burst is set by static configuration inputs that mirror the memory's already programmed mode setting. Columns inside a burst advance in sequential order within the aligned burst block, and a full-page burst runs on past the last column of the page back to column 0 until a later command ends it. A running burst can be cut short on any clock by a new write, a read or a precharge. A read or precharge releases the data bus in its own command cycle and masks that slot, which leaves at least one idle clock before read data returns at a CAS latency of 2 or 3. A counter per bank holds back writes and reads until the row-to-column delay has passed since that bank's activate.

Top module: `sdr_wr_burst_seq`

## Requirements
- R1: Every accepted command appears on the pins on the clock after its acceptance, coded as (RAS#, CAS#, WE#): activate 0,1,1 with the row on the address; write 1,0,0 and read 1,0,1 with the column on address bits [COL_W-1:0] and every other address bit, bit 10 included, at 0; precharge 0,1,0 with address bit 10 at 0 for one bank and at 1 with bank select 0 for all banks. The command codes on `cmd_op` are 0 activate, 1 write, 2 read, 3 precharge one bank, 4 precharge all.
- R2: The first word of a write is on `sd_dq_out` with `sd_dq_oe` high and `sd_dqm` clear in the same cycle as the write command on the pins; each later word of the burst is the one accepted with `wdata_ready` high on the clock before its slot.
- R3: A write or read to a bank is accepted only when that bank is open and at least TRCD clock edges have passed between the activate's acceptance and this one; an activate is accepted only to a closed bank; a write needs `wdata_valid` as well.
- R4: The burst length is taken from `cfg_bl_code` (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8) at the write's acceptance; after that many slots `sd_dq_oe` falls unless a new write follows at once.
- R5: Burst columns, shown on `slot_col` while `sd_dq_oe` is high, count up from the start column and wrap inside the burst-length-aligned block (start 13 at length 8 gives 13,14,15,8,...,12).
- R6: With `cfg_full_page` high at the write, the burst never ends by itself and the column steps from 255 to 0.
- R7: A write accepted during a burst starts the new burst at once; an accepted read or precharge ends the burst, and in its command cycle `sd_dq_oe` is low and every `sd_dqm` bit is high; the next cycle has `sd_dqm` clear.
- R8: If no word is offered in a data slot of a running burst, the slot still elapses, its column still advances and every `sd_dqm` bit is high in it.
- R9: A precharge closes its bank and precharge-all closes every bank; an activate to another bank during a burst leaves the burst's data slots unchanged.
- R10: Command codes 5 to 7 are never accepted, and a cycle after one with no accepted command shows NOP (1,1,1) with bank and address at 0.
- R11: After reset the pins show NOP, the address and bank are 0, `sd_dq_oe` is low and `sd_dqm` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_full_page | input | 1 | Full-page burst mode |
| cfg_bl_code | input | 2 | Burst length code, length = 2^code |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this clock |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BA_W | Target bank |
| cmd_addr | input | ROW_W | Row for activate, column in low bits otherwise |
| wdata_valid | input | 1 | Write word offered |
| wdata_ready | output | 1 | Write word taken this clock |
| wdata | input | DATA_W | Write word |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ROW_W | Address bus |
| sd_dq_out | output | DATA_W | Data driven to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | DATA_W/8 | Byte write masks, high masks |
| slot_col | output | COL_W | Column of the current data slot |

## Verification
The two ready outputs are combinational and are due in the same clock as the inputs that cause them, so the bench reads them one nanosecond after it drives the inputs on the falling edge. Every pin, data, mask and column output is registered once and is due one rising edge after the acceptance that caused it; the bench reads it on the falling edge that follows, against a behavioural model that tracks open banks, activate edges and the burst's remaining slots in integers. Truncation, missing words, page wrap and the row-to-column hold-off are each driven as their own short sequence with the expected slot contents worked out edge by edge.

// File: rtl/sdr_wb_pkg.sv
// Shared command codes and pin encodings for the write burst sequencer.
// Assumes a three-wire command set (RAS#, CAS#, WE#) with chip select tied active.
package sdr_wb_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_WR   = 3'd1,
        OP_RD   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4
    } op_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP = 3'b111;
    localparam cmd_pins_t PINS_ACT = 3'b011;
    localparam cmd_pins_t PINS_WR  = 3'b100;
    localparam cmd_pins_t PINS_RD  = 3'b101;
    localparam cmd_pins_t PINS_PRE = 3'b010;

endpackage

// File: rtl/sdr_bank_timer.sv
// Per-bank open flag and row-to-column delay counter.
// Each bank's counter loads on its activate and saturates at TRCD; the bank is
// ready for column commands once it has reached TRCD. Assumes TRCD >= 1 and that
// activate and precharge never fire in the same cycle (one command port).
module sdr_bank_timer #(
    parameter int BANKS = 4,
    parameter int TRCD  = 3,
    localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int CNT_W = $clog2(TRCD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic [BA_W-1:0]  act_bank,
    input  logic             pre_fire,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  pre_bank,
    output logic [BANKS-1:0] bank_open,
    output logic [BANKS-1:0] bank_rcd_ok
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;
        logic             open_q;

        // Track open state and count edges since this bank's activate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (act_fire && act_bank == BA_W'(b)) begin
                open_q <= 1'b1;
                cnt_q  <= CNT_W'(1);
            end else if (pre_fire && (pre_all || pre_bank == BA_W'(b))) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (open_q && cnt_q < CNT_W'(TRCD)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end

        assign bank_open[b]   = open_q;
        assign bank_rcd_ok[b] = open_q && (cnt_q >= CNT_W'(TRCD));

        // R3: a freshly opened bank is not yet ready unless TRCD is one cycle
        p_rcd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bank_open[b]) |-> (bank_rcd_ok[b] == (TRCD <= 1)));

        // R9: a precharge aimed at this bank closes it on the next cycle
        p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_fire && (pre_all || pre_bank == BA_W'(b))) |=> !bank_open[b]);
    end

endmodule

// File: rtl/sdr_burst_engine.sv
// Data-slot engine for write bursts: drives the data bus, byte masks and the
// slot column. A start loads the first word in the command's own cycle; later
// slots take one word per clock, masking any slot without data. A stop (read or
// precharge) releases the bus and masks its cycle. Assumes COL_W >= 3.
module sdr_burst_engine #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int MAX_BL = 8,
    localparam int MASK_W = DATA_W / 8,
    localparam int LEFT_W = $clog2(MAX_BL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl_code,
    input  logic              cfg_full_page,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [DATA_W-1:0] start_data,
    input  logic              stop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              cont,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [MASK_W-1:0] dqm,
    output logic [COL_W-1:0]  slot_col
);

    logic [COL_W-1:0]  new_mask;
    logic [COL_W-1:0]  mask_q;
    logic [COL_W-1:0]  col_step;
    logic [LEFT_W-1:0] left_q;
    logic              fp_q;

    // Column wrap mask for the burst about to start.
    always_comb begin
        if (cfg_full_page) begin
            new_mask = '1;
        end else begin
            case (cfg_bl_code)
                2'd0:    new_mask = '0;
                2'd1:    new_mask = COL_W'(1);
                2'd2:    new_mask = COL_W'(3);
                default: new_mask = COL_W'(7);
            endcase
        end
    end

    // Next column: step the low bits inside the aligned block, keep the rest.
    assign col_step = (slot_col & ~mask_q) | ((slot_col + COL_W'(1)) & mask_q);

    // A further slot is due when the burst still runs and nothing cuts it.
    assign cont = !start && !stop && (fp_q || left_q != '0);

    // Slot sequencing: load, truncate, advance or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out   <= '0;
            dq_oe    <= 1'b0;
            dqm      <= '0;
            slot_col <= '0;
            mask_q   <= '0;
            left_q   <= '0;
            fp_q     <= 1'b0;
        end else if (start) begin
            dq_out   <= start_data;
            dq_oe    <= 1'b1;
            dqm      <= '0;
            slot_col <= start_col;
            mask_q   <= new_mask;
            left_q   <= cfg_full_page ? '0 : LEFT_W'(new_mask);
            fp_q     <= cfg_full_page;
        end else if (stop) begin
            dq_oe  <= 1'b0;
            dqm    <= '1;
            left_q <= '0;
            fp_q   <= 1'b0;
        end else if (cont) begin
            slot_col <= col_step;
            dq_oe    <= 1'b1;
            if (!fp_q) begin
                left_q <= left_q - LEFT_W'(1);
            end
            if (in_valid) begin
                dq_out <= in_data;
                dqm    <= '0;
            end else begin
                dqm <= '1;
            end
        end else begin
            dq_oe <= 1'b0;
            dqm   <= '0;
        end
    end

    // R2: the word given with a start is on the bus, unmasked, next cycle
    p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (dq_oe && dqm == '0 && dq_out == $past(start_data)));

    // R6: a full-page burst keeps running unless cut
    p_fp_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_q && !start && !stop) |=> fp_q);

    // R6: the page's last column is followed by column 0
    p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_q && cont && slot_col == '1) |=> (slot_col == '0 && dq_oe));

    // R7: a stop releases the bus and masks its cycle
    p_stop_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!dq_oe && dqm == '1));

    // R4: with no slots left and no new write the bus is released
    p_burst_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_q && left_q == '0 && !start) |=> !dq_oe);

endmodule

// File: rtl/sdr_wr_burst_seq.sv
// Write burst sequencer top: accepts user commands, gates column commands on
// the per-bank row-to-column delay, registers the command pins and hands write
// data to the burst engine. Assumes ROW_W >= 11, COL_W <= 10, power-of-two BANKS,
// and that the user respects row precharge and refresh timing itself.
module sdr_wr_burst_seq
    import sdr_wb_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int TRCD   = 3,
    localparam int BA_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_full_page,
    input  logic [1:0]        cfg_bl_code,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [BA_W-1:0]   cmd_bank,
    input  logic [ROW_W-1:0]  cmd_addr,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [DATA_W-1:0] wdata,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [COL_W-1:0]  slot_col
);

    localparam int AP_BIT = 10;

    logic [BANKS-1:0] bank_open;
    logic [BANKS-1:0] bank_rcd_ok;
    logic             cmd_fire, act_fire, wr_fire, rd_fire, pre_fire, pre_all;
    logic             eng_cont;
    cmd_pins_t        pins_q;

    // Decide whether the offered command can be taken this cycle.
    always_comb begin
        case (cmd_op)
            OP_ACT:          cmd_ready = !bank_open[cmd_bank];
            OP_WR:           cmd_ready = bank_rcd_ok[cmd_bank] && wdata_valid;
            OP_RD:           cmd_ready = bank_rcd_ok[cmd_bank];
            OP_PRE, OP_PREA: cmd_ready = 1'b1;
            default:         cmd_ready = 1'b0;
        endcase
    end

    assign cmd_fire = cmd_valid && cmd_ready;
    assign act_fire = cmd_fire && cmd_op == OP_ACT;
    assign wr_fire  = cmd_fire && cmd_op == OP_WR;
    assign rd_fire  = cmd_fire && cmd_op == OP_RD;
    assign pre_all  = cmd_op == OP_PREA;
    assign pre_fire = cmd_fire && (cmd_op == OP_PRE || pre_all);

    assign wdata_ready = wr_fire || eng_cont;

    // Register the command pins, bank and address for the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q  <= PINS_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
        end else begin
            pins_q  <= PINS_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
            if (cmd_fire) begin
                case (cmd_op)
                    OP_ACT: begin
                        pins_q  <= PINS_ACT;
                        sd_ba   <= cmd_bank;
                        sd_addr <= cmd_addr;
                    end
                    OP_WR: begin
                        pins_q  <= PINS_WR;
                        sd_ba   <= cmd_bank;
                        sd_addr <= ROW_W'(cmd_addr[COL_W-1:0]);
                    end
                    OP_RD: begin
                        pins_q  <= PINS_RD;
                        sd_ba   <= cmd_bank;
                        sd_addr <= ROW_W'(cmd_addr[COL_W-1:0]);
                    end
                    OP_PRE: begin
                        pins_q <= PINS_PRE;
                        sd_ba  <= cmd_bank;
                    end
                    default: begin
                        pins_q          <= PINS_PRE;
                        sd_addr[AP_BIT] <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign sd_ras_n = pins_q.ras_n;
    assign sd_cas_n = pins_q.cas_n;
    assign sd_we_n  = pins_q.we_n;

    sdr_bank_timer #(
        .BANKS (BANKS),
        .TRCD  (TRCD)
    ) u_bank_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_fire    (act_fire),
        .act_bank    (cmd_bank),
        .pre_fire    (pre_fire),
        .pre_all     (pre_all),
        .pre_bank    (cmd_bank),
        .bank_open   (bank_open),
        .bank_rcd_ok (bank_rcd_ok)
    );

    sdr_burst_engine #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_burst_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_bl_code   (cfg_bl_code),
        .cfg_full_page (cfg_full_page),
        .start         (wr_fire),
        .start_col     (cmd_addr[COL_W-1:0]),
        .start_data    (wdata),
        .stop          (rd_fire || pre_fire),
        .in_valid      (wdata_valid),
        .in_data       (wdata),
        .cont          (eng_cont),
        .dq_out        (sd_dq_out),
        .dq_oe         (sd_dq_oe),
        .dqm           (sd_dqm),
        .slot_col      (slot_col)
    );

    // R10: a cycle with no accepted command is followed by NOP pins
    p_nop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_fire |=> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0));

    // R2: a write command on the pins carries its first word, unmasked
    p_wr_with_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_dq_oe && sd_dqm == '0));

    // R7: a read on the pins never has the data bus driven
    p_read_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ras_n && !sd_cas_n && sd_we_n) |-> !sd_dq_oe);

    // R1: column commands never request auto precharge
    p_col_no_ap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ras_n && !sd_cas_n) |-> !sd_addr[AP_BIT]);

endmodule

// File: tb/sdr_wr_burst_seq_bench.sv
module sdr_wr_burst_seq_bench;

    localparam int TRCD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_full_page = 1'b0;
    logic [1:0]  cfg_bl_code = 2'd2;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic [11:0] cmd_addr = 12'd0;
    logic        wdata_valid = 1'b0;
    logic        wdata_ready;
    logic [15:0] wdata = 16'd0;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [1:0]  sd_dqm;
    logic [7:0]  slot_col;

    always #10 clk = ~clk;

    sdr_wr_burst_seq #(.TRCD(TRCD)) u_sdr_wr_burst_seq (
        .clk(clk), .rst_n(rst_n), .cfg_full_page(cfg_full_page), .cfg_bl_code(cfg_bl_code),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm),
        .slot_col(slot_col)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    int  edge_n = 0;
    bit  m_open[4];
    int  m_act[4];
    int  m_left = 0;
    bit  m_fp = 1'b0;
    int  m_len = 1;
    int  m_col = 0;
    int  e_pins = 7, e_ba = 0, e_addr = 0, e_oe = 0, e_dqm = 0, e_dq = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check readies, advance the model,
    // then check the registered outputs at the next falling edge.
    task automatic step(input bit cv, input int op, input int bk, input int ad,
                        input bit dv, input int dat, input string tag);
        bit rdy, fire, cut, more;
        cmd_valid = cv; cmd_op = op[2:0]; cmd_bank = bk[1:0]; cmd_addr = ad[11:0];
        wdata_valid = dv; wdata = dat[15:0];
        #1;
        case (op)
            0:       rdy = !m_open[bk];
            1:       rdy = m_open[bk] && (edge_n - m_act[bk] >= TRCD) && dv;
            2:       rdy = m_open[bk] && (edge_n - m_act[bk] >= TRCD);
            3, 4:    rdy = 1'b1;
            default: rdy = 1'b0;
        endcase
        fire = cv && rdy;
        cut  = fire && op >= 1 && op <= 4;
        more = !cut && (m_fp || m_left > 0);
        check(tag, "cmd_ready", int'(cmd_ready), int'(rdy));
        check(tag, "wdata_ready", int'(wdata_ready), int'((fire && op == 1) || more));
        e_pins = 7; e_ba = 0; e_addr = 0;
        if (fire) begin
            case (op)
                0: begin e_pins = 3; e_ba = bk; e_addr = ad; m_open[bk] = 1'b1; m_act[bk] = edge_n; end
                1: begin e_pins = 4; e_ba = bk; e_addr = ad % 256; end
                2: begin e_pins = 5; e_ba = bk; e_addr = ad % 256; end
                3: begin e_pins = 2; e_ba = bk; m_open[bk] = 1'b0; end
                default: begin
                    e_pins = 2; e_addr = 1024;
                    foreach (m_open[i]) m_open[i] = 1'b0;
                end
            endcase
        end
        if (fire && op == 1) begin
            m_fp = cfg_full_page;
            m_len = cfg_full_page ? 256 : (1 << cfg_bl_code);
            m_col = ad % 256;
            m_left = cfg_full_page ? 0 : m_len - 1;
            e_oe = 1; e_dqm = 0; e_dq = dat;
        end else if (cut) begin
            m_left = 0; m_fp = 1'b0; e_oe = 0; e_dqm = 3;
        end else if (more) begin
            m_col = (m_col / m_len) * m_len + ((m_col % m_len) + 1) % m_len;
            if (!m_fp) m_left--;
            e_oe = 1;
            if (dv) begin e_dq = dat; e_dqm = 0; end
            else e_dqm = 3;
        end else begin
            e_oe = 0; e_dqm = 0;
        end
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        check(tag, "cmd pins", int'({sd_ras_n, sd_cas_n, sd_we_n}), e_pins);
        check(tag, "bank", int'(sd_ba), e_ba);
        check(tag, "addr", int'(sd_addr), e_addr);
        check(tag, "dq_oe", int'(sd_dq_oe), e_oe);
        check(tag, "dqm", int'(sd_dqm), e_dqm);
        if (e_oe == 1 && e_dqm == 0) check(tag, "dq", int'(sd_dq_out), e_dq);
        if (e_oe == 1) check(tag, "slot_col", int'(slot_col), m_col);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 0, 0, 1'b0, 0, tag);
    endtask

    initial begin
        foreach (m_open[i]) begin m_open[i] = 1'b0; m_act[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "cmd pins", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check("R11", "addr", int'(sd_addr), 0);
        check("R11", "dq_oe", int'(sd_dq_oe), 0);
        check("R11", "dqm", int'(sd_dqm), 0);
        rst_n = 1'b1;

        // R10: unknown codes are refused
        step(1'b1, 5, 0, 0, 1'b1, 16'h1111, "R10");
        step(1'b1, 7, 1, 3, 1'b0, 0, "R10");
        idle("R10");

        // R3: activate then write held off until the delay has passed
        cfg_bl_code = 2'd2;
        step(1'b1, 0, 0, 12'h123, 1'b0, 0, "R1");
        step(1'b1, 1, 0, 4, 1'b1, 16'hA000, "R3");
        step(1'b1, 1, 0, 4, 1'b1, 16'hA001, "R3");
        step(1'b1, 1, 0, 4, 1'b1, 16'hA002, "R2");
        step(1'b1, 0, 0, 12'h55, 1'b1, 16'hA003, "R3");
        for (int k = 0; k < 2; k++) step(1'b0, 0, 0, 0, 1'b1, 16'hA010 + k, "R2");
        idle("R4");
        idle("R4");

        // R8: a missing word masks its slot and the column still moves
        step(1'b1, 1, 0, 9, 1'b1, 16'hB000, "R8");
        step(1'b0, 0, 0, 0, 1'b0, 0, "R8");
        step(1'b0, 0, 0, 0, 1'b1, 16'hB002, "R8");
        step(1'b0, 0, 0, 0, 1'b1, 16'hB003, "R8");
        idle("R4");

        // R5: length 8 wraps inside its aligned block
        cfg_bl_code = 2'd3;
        step(1'b1, 1, 0, 13, 1'b1, 16'hC000, "R5");
        for (int k = 1; k < 8; k++) step(1'b0, 0, 0, 0, 1'b1, 16'hC000 + k, "R5");
        idle("R4");

        // R4: lengths 1 and 2
        cfg_bl_code = 2'd0;
        step(1'b1, 1, 0, 3, 1'b1, 16'hD000, "R4");
        idle("R4");
        cfg_bl_code = 2'd1;
        step(1'b1, 1, 0, 3, 1'b1, 16'hD100, "R4");
        step(1'b0, 0, 0, 0, 1'b1, 16'hD101, "R5");
        idle("R4");

        // R7: write cut by a write, then by a read, then by a precharge
        cfg_bl_code = 2'd2;
        step(1'b1, 1, 0, 0, 1'b1, 16'hE000, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 16'hE001, "R7");
        step(1'b1, 1, 0, 20, 1'b1, 16'hE100, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 16'hE101, "R7");
        step(1'b1, 2, 0, 20, 1'b1, 16'hE102, "R7");
        idle("R7");
        step(1'b1, 1, 0, 40, 1'b1, 16'hE200, "R7");
        step(1'b0, 0, 0, 0, 1'b1, 16'hE201, "R7");
        step(1'b1, 3, 0, 0, 1'b1, 16'hE202, "R7");
        idle("R7");
        step(1'b1, 1, 0, 8, 1'b1, 16'hE300, "R9");

        // R9: activate during a burst, precharge-all, reopen
        step(1'b1, 0, 1, 5, 1'b0, 0, "R9");
        step(1'b1, 0, 2, 6, 1'b0, 0, "R9");
        idle("R9");
        idle("R9");
        step(1'b1, 1, 1, 0, 1'b1, 16'hF000, "R9");
        step(1'b1, 0, 3, 7, 1'b1, 16'hF001, "R9");
        step(1'b0, 0, 0, 0, 1'b1, 16'hF002, "R9");
        step(1'b0, 0, 0, 0, 1'b1, 16'hF003, "R9");
        idle("R9");
        step(1'b1, 4, 2, 0, 1'b0, 0, "R1");
        step(1'b1, 1, 1, 0, 1'b1, 16'hF100, "R9");
        step(1'b1, 0, 1, 9, 1'b0, 0, "R9");
        step(1'b1, 0, 1, 9, 1'b0, 0, "R3");
        idle("R3");
        idle("R3");

        // R6: full page runs across the page end until a precharge
        cfg_full_page = 1'b1;
        step(1'b1, 1, 1, 253, 1'b1, 16'h6000, "R6");
        for (int k = 1; k < 8; k++) step(1'b0, 0, 0, 0, 1'b1, 16'h6000 + k, "R6");
        step(1'b1, 3, 1, 0, 1'b1, 16'h6100, "R6");
        idle("R6");
        cfg_full_page = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule